// File: doc/BRIEF.md
# Receiver Error Hold and Interrupt Logic

This block sits after the frame decoder of a digital audio receiver. Every decoded subframe arrives with its channel tag and its error flags. The block passes good subframes through to the serial audio output. When a subframe is damaged it outputs a substitute instead: the last clean sample of the same channel after a decode error, or silence after loss of lock.

The block also keeps three sticky status flags that stay set until the host reads the status register. It holds a captured channel-status word, and loss of lock does not disturb it. It drives two host interrupt pins. Each pin sees the same eight event sources through its own mask. Each pin also has its own stretch time, counted in LRCK periods, so that a brief event stays visible long enough for the host to service it.

Top module: `rx_err_irq`

## Requirements
- R1: A subframe with `sub_valid` high and no error flag while locked appears on `out_data`/`out_chan` with `out_valid` high one clock later, unchanged.
- R2: A subframe flagged with a parity, biphase or frame-length error while locked is replaced by the last error-free subframe of the same channel (zero if none since reset), and does not update that stored value.
- R3: The stored last-good value is kept separately for the left channel (`sub_chan`=0) and the right channel (`sub_chan`=1).
- R4: A subframe that arrives while `unlock` is high is output as zero, whatever its error flags, and does not update the stored last-good value.
- R5: `st_flags` bit 0 (parity error), bit 1 (channel-status change) and bit 2 (new Q data) are set by their events and stay at 1 until a cycle with `stat_rd` high, after which they read 0. An event in the same cycle as `stat_rd` leaves its bit at 1.
- R6: The event vector is bit 0 unlock (level), bit 1 parity, bit 2 biphase, bit 3 frame length (bits 1 to 3 count only with `sub_valid`), bit 4 non-audio, bit 5 channel-status change, bit 6 new Q data, bit 7 emphasis change. An event whose mask bit is 0 sets that pin high from the next clock. A mask bit of 1 blocks that event for that pin only.
- R7: After the last unmasked event, a pin stays high for exactly N `lrck_tick` pulses, with N = 512 for select 00, 1024 for 01, 2048 for 10 and 4096 for 11. A new event restarts the count. Without ticks the pin stays high.
- R8: `cs_kept` takes `cs_in` on `cs_load` while locked. While `unlock` is high, loads are ignored and the value is kept.
- R9: After reset, `out_valid`, `out_chan`, `out_data`, `st_flags`, `cs_kept`, `irq0` and `irq1` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Decoded subframe strobe |
| sub_chan | input | 1 | Channel of subframe, 0 left, 1 right |
| sub_data | input | 24 | Decoded audio sample |
| err_parity | input | 1 | Parity error on this subframe |
| err_biphase | input | 1 | Biphase coding error on this subframe |
| err_framelen | input | 1 | Frame length error on this subframe |
| unlock | input | 1 | Receiver clock recovery not locked (level) |
| ev_nonaudio | input | 1 | Non-audio stream detected pulse |
| ev_cs_chg | input | 1 | Channel-status changed pulse |
| ev_q_new | input | 1 | New Q-subcode data pulse |
| ev_emph_chg | input | 1 | Emphasis setting changed pulse |
| lrck_tick | input | 1 | One pulse per LRCK period |
| stat_rd | input | 1 | Status register read strobe |
| cs_load | input | 1 | Load strobe for channel-status word |
| cs_in | input | 40 | Channel-status word from decoder |
| mask0 | input | 8 | Per-event mask for pin 0, 1 blocks |
| mask1 | input | 8 | Per-event mask for pin 1, 1 blocks |
| hold0_sel | input | 2 | Stretch select for pin 0 |
| hold1_sel | input | 2 | Stretch select for pin 1 |
| out_valid | output | 1 | Output subframe strobe |
| out_chan | output | 1 | Output subframe channel |
| out_data | output | 24 | Output (possibly substituted) sample |
| st_flags | output | 3 | Sticky parity / cs-change / Q flags |
| cs_kept | output | 40 | Held channel-status word |
| irq0 | output | 1 | Interrupt pin 0 |
| irq1 | output | 1 | Interrupt pin 1 |

## Verification
The substitution path is tried with all sixteen combinations of the three decode flags and unlock, alternating between the two channels. Distinct sample values per step show whether a repeat came from the correct channel and whether damaged samples were kept out of the stored value. The interrupt pins are driven with single-cycle events from each of the eight sources under complementary masks, which separates the two pins and exposes any miswired mask bit. The stretch length is measured for all four select codes, with the two pins set to different codes at the same time, and again with a mid-stretch reload and with ticks paused.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
    localparam int SUB_W      = 24;
    localparam int NUM_EV     = 8;
    localparam int NUM_IRQ    = 2;
    localparam int NUM_STICKY = 3;
    localparam int SEL_W      = 2;

    localparam int EV_UNLOCK   = 0;
    localparam int EV_PARITY   = 1;
    localparam int EV_BIPHASE  = 2;
    localparam int EV_FRAMELEN = 3;
    localparam int EV_NONAUDIO = 4;
    localparam int EV_CSCHG    = 5;
    localparam int EV_QNEW     = 6;
    localparam int EV_EMPH     = 7;

    localparam int ST_PAR = 0;
    localparam int ST_CS  = 1;
    localparam int ST_Q   = 2;

    typedef struct packed {
        logic             chan;
        logic [SUB_W-1:0] data;
    } sub_t;

    typedef enum logic [1:0] {
        SUB_PASS   = 2'd0,
        SUB_REPEAT = 2'd1,
        SUB_ZERO   = 2'd2
    } sub_act_e;

    function automatic int unsigned hold_len(input logic [SEL_W-1:0] sel,
                                             input int unsigned base);
        return base << sel;
    endfunction
endpackage

// File: rtl/rx_sub_hold.sv
module rx_sub_hold
    import rx_err_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  sub_t sub_in,
    input  logic err_par,
    input  logic err_bip,
    input  logic err_flen,
    input  logic unlock,
    output logic out_valid,
    output sub_t sub_out
);
    logic [SUB_W-1:0] last_q [2];
    sub_act_e         act;
    logic             any_err;

    assign any_err = err_par | err_bip | err_flen;

    always_comb begin
        if (unlock)       act = SUB_ZERO;
        else if (any_err) act = SUB_REPEAT;
        else              act = SUB_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            sub_out   <= '0;
            last_q[0] <= '0;
            last_q[1] <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sub_out.chan <= sub_in.chan;
                unique case (act)
                    SUB_ZERO:   sub_out.data <= '0;
                    SUB_REPEAT: sub_out.data <= last_q[sub_in.chan];
                    default: begin
                        sub_out.data         <= sub_in.data;
                        last_q[sub_in.chan]  <= sub_in.data;
                    end
                endcase
            end
        end
    end

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unlock && !any_err) |=> (out_valid && sub_out.data == $past(sub_in.data))); // R1
    AST_UNLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && unlock) |=> (out_valid && sub_out.data == '0)); // R4
    AST_CHAN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (sub_out.chan == $past(sub_in.chan))); // R1
endmodule

// File: rtl/rx_status_keep.sv
module rx_status_keep
    import rx_err_pkg::*;
#(
    parameter int CS_W = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STICKY-1:0] set_vec,
    input  logic                  rd,
    input  logic                  unlock,
    input  logic                  cs_load,
    input  logic [CS_W-1:0]       cs_in,
    output logic [NUM_STICKY-1:0] st_q,
    output logic [CS_W-1:0]       cs_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            cs_q <= '0;
        end else begin
            st_q <= set_vec | (st_q & {NUM_STICKY{~rd}});
            if (cs_load && !unlock) cs_q <= cs_in;
        end
    end

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !rd |=> ((st_q & $past(st_q)) == $past(st_q))); // R5
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((st_q & $past(set_vec)) == $past(set_vec))); // R5
    AST_CS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        unlock |=> $stable(cs_q)); // R8
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
    import rx_err_pkg::*;
#(
    parameter int HOLD_BASE = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_vec,
    input  logic [NUM_EV-1:0] mask,
    input  logic [SEL_W-1:0]  hold_sel,
    input  logic              lrck_tick,
    output logic              irq
);
    localparam int MAX_HOLD = HOLD_BASE << ((1 << SEL_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HOLD + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = |(ev_vec & ~mask);

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (hit)                     cnt_q <= CNT_W'(hold_len(hold_sel, HOLD_BASE));
        else if (lrck_tick && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign irq = (cnt_q != '0);

    AST_EVENT_RAISES: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!irq && !hit) |=> !irq); // R6
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (irq && !lrck_tick) |=> irq); // R7
endmodule

// File: rtl/rx_err_irq.sv
module rx_err_irq
    import rx_err_pkg::*;
#(
    parameter int CS_W      = 40,
    parameter int HOLD_BASE = 512
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sub_valid,
    input  logic                  sub_chan,
    input  logic [SUB_W-1:0]      sub_data,
    input  logic                  err_parity,
    input  logic                  err_biphase,
    input  logic                  err_framelen,
    input  logic                  unlock,
    input  logic                  ev_nonaudio,
    input  logic                  ev_cs_chg,
    input  logic                  ev_q_new,
    input  logic                  ev_emph_chg,
    input  logic                  lrck_tick,
    input  logic                  stat_rd,
    input  logic                  cs_load,
    input  logic [CS_W-1:0]       cs_in,
    input  logic [NUM_EV-1:0]     mask0,
    input  logic [NUM_EV-1:0]     mask1,
    input  logic [SEL_W-1:0]      hold0_sel,
    input  logic [SEL_W-1:0]      hold1_sel,
    output logic                  out_valid,
    output logic                  out_chan,
    output logic [SUB_W-1:0]      out_data,
    output logic [NUM_STICKY-1:0] st_flags,
    output logic [CS_W-1:0]       cs_kept,
    output logic                  irq0,
    output logic                  irq1
);
    sub_t                  sub_in, sub_out;
    logic [NUM_EV-1:0]     ev_vec;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_EV-1:0]     mask_a [NUM_IRQ];
    logic [SEL_W-1:0]      sel_a  [NUM_IRQ];
    logic [NUM_IRQ-1:0]    irq_v;

    assign sub_in.chan = sub_chan;
    assign sub_in.data = sub_data;

    always_comb begin
        ev_vec              = '0;
        ev_vec[EV_UNLOCK]   = unlock;
        ev_vec[EV_PARITY]   = sub_valid & err_parity;
        ev_vec[EV_BIPHASE]  = sub_valid & err_biphase;
        ev_vec[EV_FRAMELEN] = sub_valid & err_framelen;
        ev_vec[EV_NONAUDIO] = ev_nonaudio;
        ev_vec[EV_CSCHG]    = ev_cs_chg;
        ev_vec[EV_QNEW]     = ev_q_new;
        ev_vec[EV_EMPH]     = ev_emph_chg;
    end

    always_comb begin
        sticky_set         = '0;
        sticky_set[ST_PAR] = ev_vec[EV_PARITY];
        sticky_set[ST_CS]  = ev_vec[EV_CSCHG];
        sticky_set[ST_Q]   = ev_vec[EV_QNEW];
    end

    rx_sub_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sub_valid),
        .sub_in    (sub_in),
        .err_par   (err_parity),
        .err_bip   (err_biphase),
        .err_flen  (err_framelen),
        .unlock    (unlock),
        .out_valid (out_valid),
        .sub_out   (sub_out)
    );

    assign out_chan = sub_out.chan;
    assign out_data = sub_out.data;

    rx_status_keep #(.CS_W(CS_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (sticky_set),
        .rd      (stat_rd),
        .unlock  (unlock),
        .cs_load (cs_load),
        .cs_in   (cs_in),
        .st_q    (st_flags),
        .cs_q    (cs_kept)
    );

    assign mask_a[0] = mask0;
    assign mask_a[1] = mask1;
    assign sel_a[0]  = hold0_sel;
    assign sel_a[1]  = hold1_sel;

    for (genvar p = 0; p < NUM_IRQ; p++) begin : g_pin
        rx_irq_gen #(.HOLD_BASE(HOLD_BASE)) u_irq (
            .clk       (clk),
            .rst       (rst),
            .ev_vec    (ev_vec),
            .mask      (mask_a[p]),
            .hold_sel  (sel_a[p]),
            .lrck_tick (lrck_tick),
            .irq       (irq_v[p])
        );
    end

    assign irq0 = irq_v[0];
    assign irq1 = irq_v[1];
endmodule

// File: tb/rx_err_irq_tb.sv
`timescale 1ns/1ps
module rx_err_irq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sub_valid = 0, sub_chan = 0;
    logic [23:0] sub_data = '0;
    logic        err_parity = 0, err_biphase = 0, err_framelen = 0, unlock = 0;
    logic        ev_nonaudio = 0, ev_cs_chg = 0, ev_q_new = 0, ev_emph_chg = 0;
    logic        lrck_tick = 1, stat_rd = 0, cs_load = 0;
    logic [39:0] cs_in = '0;
    logic [7:0]  mask0 = '0, mask1 = '0;
    logic [1:0]  hold0_sel = '0, hold1_sel = '0;
    logic        out_valid, out_chan;
    logic [23:0] out_data;
    logic [2:0]  st_flags;
    logic [39:0] cs_kept;
    logic        irq0, irq1;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rx_err_irq u_dut (
        .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_chan(sub_chan),
        .sub_data(sub_data), .err_parity(err_parity), .err_biphase(err_biphase),
        .err_framelen(err_framelen), .unlock(unlock), .ev_nonaudio(ev_nonaudio),
        .ev_cs_chg(ev_cs_chg), .ev_q_new(ev_q_new), .ev_emph_chg(ev_emph_chg),
        .lrck_tick(lrck_tick), .stat_rd(stat_rd), .cs_load(cs_load), .cs_in(cs_in),
        .mask0(mask0), .mask1(mask1), .hold0_sel(hold0_sel), .hold1_sel(hold1_sel),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
        .st_flags(st_flags), .cs_kept(cs_kept), .irq0(irq0), .irq1(irq1)
    );

    task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drain();
        for (int g = 0; g < 10000; g++) begin
            if (!irq0 && !irq1) break;
            @(negedge clk);
        end
    endtask

    // one-cycle event of index idx per the R6 encoding; returns at the negedge after it is sampled
    task automatic fire(input int idx);
        case (idx)
            0: unlock = 1;
            1: begin sub_valid = 1; err_parity = 1; end
            2: begin sub_valid = 1; err_biphase = 1; end
            3: begin sub_valid = 1; err_framelen = 1; end
            4: ev_nonaudio = 1;
            5: ev_cs_chg = 1;
            6: ev_q_new = 1;
            default: ev_emph_chg = 1;
        endcase
        @(negedge clk);
        unlock = 0; sub_valid = 0; err_parity = 0; err_biphase = 0; err_framelen = 0;
        ev_nonaudio = 0; ev_cs_chg = 0; ev_q_new = 0; ev_emph_chg = 0;
    endtask

    task automatic measure(output int n0, output int n1);
        n0 = 0; n1 = 0;
        for (int g = 0; g < 10000; g++) begin
            if (!irq0 && !irq1) break;
            if (irq0) n0++;
            if (irq1) n1++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [23:0] last_g [2];
        int n0, n1;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", out_valid == 0, out_valid, 0);
        chk("R9 out_data", out_data == 0 && out_chan == 0, out_data, 0);
        chk("R9 st_flags", st_flags == 0, st_flags, 0);
        chk("R9 cs_kept", cs_kept == 0, cs_kept, 0);
        chk("R9 irq", irq0 == 0 && irq1 == 0, {irq0, irq1}, 0);
        rst = 0;
        @(negedge clk);

        // R1 R2 R3 R4 substitution sweep
        last_g[0] = '0; last_g[1] = '0;
        for (int pat = 0; pat < 16; pat++) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [23:0] d, e;
                logic er;
                d = 24'((pat * 4099 + ch * 70001 + 17) & 24'hFFFFFF);
                er = pat[0] | pat[1] | pat[2];
                sub_valid = 1; sub_chan = ch[0]; sub_data = d;
                err_parity = pat[0]; err_biphase = pat[1]; err_framelen = pat[2]; unlock = pat[3];
                if (pat[3]) e = '0;
                else if (er) e = last_g[ch];
                else begin e = d; last_g[ch] = d; end
                @(negedge clk);
                if (pat[3]) chk("R4 unlock zero", out_data == e, out_data, e);
                else if (er) chk("R2 R3 repeat last good", out_data == e, out_data, e);
                else chk("R1 pass", out_data == e, out_data, e);
                chk("R1 valid/chan", out_valid && out_chan == ch[0], {out_valid, out_chan}, {1'b1, ch[0]});
            end
        end
        sub_valid = 0; err_parity = 0; err_biphase = 0; err_framelen = 0; unlock = 0;
        @(negedge clk);
        chk("R1 valid drops", out_valid == 0, out_valid, 0);
        drain();

        // R5 sticky flags
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        chk("R5 cleared", st_flags == 0, st_flags, 0);
        fire(1);
        chk("R5 parity set", st_flags == 3'b001, st_flags, 1);
        repeat (5) @(negedge clk);
        chk("R5 parity stays", st_flags == 3'b001, st_flags, 1);
        fire(5);
        fire(6);
        chk("R5 all set", st_flags == 3'b111, st_flags, 7);
        stat_rd = 1; ev_q_new = 1; @(negedge clk); stat_rd = 0; ev_q_new = 0;
        chk("R5 read with event keeps Q", st_flags == 3'b100, st_flags, 4);
        stat_rd = 1; @(negedge clk); stat_rd = 0;
        chk("R5 read clears", st_flags == 0, st_flags, 0);
        drain();

        // R8 channel-status hold
        cs_in = 40'h12_3456_789A; cs_load = 1; @(negedge clk); cs_load = 0;
        chk("R8 load locked", cs_kept == 40'h12_3456_789A, cs_kept, 40'h12_3456_789A);
        unlock = 1; cs_in = 40'hFF_0000_00FF; cs_load = 1; @(negedge clk);
        cs_load = 0; @(negedge clk);
        chk("R8 kept while unlocked", cs_kept == 40'h12_3456_789A, cs_kept, 40'h12_3456_789A);
        unlock = 0; cs_load = 1; @(negedge clk); cs_load = 0;
        chk("R8 load after relock", cs_kept == 40'hFF_0000_00FF, cs_kept, 40'hFF_0000_00FF);
        drain();

        // R7 hold length for every select code, pins on different codes
        for (int c = 0; c < 4; c++) begin
            hold0_sel = 2'(c); hold1_sel = 2'(3 - c);
            fire(4);
            measure(n0, n1);
            chk("R7 pin0 hold", n0 == (512 << c), n0, 512 << c);
            chk("R7 pin1 hold", n1 == (512 << (3 - c)), n1, 512 << (3 - c));
        end
        hold0_sel = 0; hold1_sel = 0;

        // R6 per-event masks, complementary pins
        for (int i = 0; i < 8; i++) begin
            mask0 = 8'(1 << i); mask1 = 8'h00;
            fire(i);
            measure(n0, n1);
            chk("R6 masked pin0 quiet", n0 == 0, n0, 0);
            chk("R6 pin1 sees event", n1 == 512, n1, 512);
            mask0 = 8'h00; mask1 = 8'(1 << i);
            fire(i);
            measure(n0, n1);
            chk("R6 pin0 sees event", n0 == 512, n0, 512);
            chk("R6 masked pin1 quiet", n1 == 0, n1, 0);
        end
        mask0 = 0; mask1 = 0;

        // R7 reload by a new event
        fire(7);
        repeat (300) @(negedge clk);
        fire(7);
        measure(n0, n1);
        chk("R7 reload", n0 == 512 && n1 == 512, n0, 512);

        // R7 no ticks keeps the pin high
        fire(5);
        lrck_tick = 0;
        for (int k = 0; k < 100; k++) begin
            if (!irq0) begin chk("R7 held without tick", 0, irq0, 1); break; end
            @(negedge clk);
        end
        chk("R7 still high after pause", irq0 && irq1, irq0, 1);
        lrck_tick = 1;
        measure(n0, n1);
        chk("R7 count resumes", n0 == 512, n0, 512);
        stat_rd = 1; @(negedge clk); stat_rd = 0;

        summary();
    end
endmodule